// File: doc/BRIEF.md
# Pipelined Radix-4 Word Rotator

This block turns a 32-bit data word to the left by an amount taken from the five least significant bits of a second operand. The selection is done in levels. Each of the first two levels settles two amount bits with one four-way choice. The last level settles the remaining bit with a two-way choice. The word therefore passes through three levels of selection instead of five. A build parameter places zero to three register levels behind the first selection levels. An addend word travels down the pipeline next to the data, so it leaves together with its own result.

A second build option folds a 32-bit adder into the last selection level. In that case the block delivers the rotated word plus the addend, modulo 2^32. In the plain build the block delivers the rotated word alone. In both builds the addend is carried to the output unchanged, for logic further downstream.

Both ends of the block are valid/ready streams. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. All register levels advance together. When `out_ready` is low while `out_valid` is high, every level holds. In that case `in_ready` drops and the upstream side must keep its word and its valid steady until the word is taken.

Top module: `radix4_rotator`

## Requirements
- R1: In the plain build, `out_data` equals `in_data` rotated left by `in_amt[4:0]` places. Bit j of the input moves to bit (j+amt) mod 32. An amount of 0 passes the word unchanged.
- R2: Bits of `in_amt` above bit 4 have no effect on `out_data` or on `out_addend`.
- R3: With `FUSE_ADD`=1, `out_data` equals the R1 rotation plus `in_addend`, modulo 2^32. For example, 0xFFFFFFFF plus 1 gives 0.
- R4: `out_addend` carries the `in_addend` of the same item unchanged, in both builds.
- R5: While `out_ready` stays high, a result appears `PIPE` clock edges after the edge that accepted its input. With `PIPE`=0 the path is combinational and the result appears in the same cycle.
- R6: When `out_valid` is high and `out_ready` is low, in the next cycle `out_valid` is still high and `out_data` and `out_addend` are unchanged. Results leave in acceptance order, and none is lost or repeated.
- R7: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low.
- R8: While `rst_n` is low (asynchronous, active low), `out_valid` is low in builds with `PIPE` of 1 or more. It is still low on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word on this edge |
| in_data | input | DATA_W | Word to rotate |
| in_amt | input | AMT_W | Rotate amount; only bits [4:0] are used |
| in_addend | input | DATA_W | Side operand carried with the word (added in fused build) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result on this edge |
| out_data | output | DATA_W | Rotated word, or rotated word plus addend |
| out_addend | output | DATA_W | Addend delayed to line up with out_data |

## Verification
The hold property on the output stream assumes that the upstream side obeys the stream rule: once `in_valid` is raised, the word, amount and addend stay fixed until the word is accepted. In the combinational build this assumption is what keeps a stalled output steady. The bench driver follows the rule. It raises `in_valid` only with a complete word and changes the word only after it sees `in_ready` on an accepting edge. Idle gaps are inserted only between accepted words. The stage-level count-of-ones check assumes nothing about the amount, and the stimulus draws every amount bit at random, including the ignored upper bits.

// File: rtl/rot4_pkg.sv
package rot4_pkg;

  // Number of selection levels for a shift amount of shw bits.
  function automatic int stage_count(input int shw);
    return (shw + 1) / 2;
  endfunction

  // Rotate step (in bit places) represented by selector value 1 at level i.
  function automatic int stage_unit(input int i);
    return 1 << (2 * i);
  endfunction

  // Level i resolves two amount bits unless only one bit remains.
  function automatic bit stage_is_radix4(input int i, input int shw);
    return (2 * i + 1) < shw;
  endfunction

endpackage

// File: rtl/rot4_sel_stage.sv
module rot4_sel_stage #(
  parameter int W      = 32,
  parameter int UNIT   = 1,
  parameter bit RADIX4 = 1'b1,
  localparam int SEL_W = RADIX4 ? 2 : 1
) (
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);

  function automatic logic [W-1:0] rotc(input logic [W-1:0] x, input int n);
    logic [2*W-1:0] t;
    t = {x, x} << n;
    return t[2*W-1:W];
  endfunction

  generate
    if (RADIX4) begin : g_four
      always_comb begin
        unique case (sel)
          2'd0:    dout = din;
          2'd1:    dout = rotc(din, UNIT);
          2'd2:    dout = rotc(din, 2 * UNIT);
          default: dout = rotc(din, 3 * UNIT);
        endcase
      end
    end else begin : g_two
      always_comb dout = sel[0] ? rotc(din, UNIT) : din;
    end
  endgenerate

  // A rotation only moves bits: the count of ones stays the same (R1).
  always_comb begin
    p_ones_kept_r1: assert ($countones(dout) == $countones(din));
  end

endmodule

// File: rtl/rot4_stage_reg.sv
module rot4_stage_reg #(
  parameter int PW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vin,
  input  logic [PW-1:0] din,
  output logic          vout,
  output logic [PW-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vout <= 1'b0;
    else if (en) vout <= vin;
  end

  always_ff @(posedge clk) begin
    if (en) dout <= din;
  end

endmodule

// File: rtl/radix4_rotator.sv
module radix4_rotator
  import rot4_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AMT_W    = 8,
  parameter int PIPE     = 2,
  parameter bit FUSE_ADD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic [DATA_W-1:0] in_addend,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] out_addend
);

  localparam int SHW  = $clog2(DATA_W);
  localparam int NST  = stage_count(SHW);
  localparam int NREG = (PIPE > NST) ? NST : PIPE;
  localparam int PW   = 2 * DATA_W + SHW;

  logic [DATA_W-1:0] s_data [NST+1];
  logic [SHW-1:0]    s_amt  [NST+1];
  logic [DATA_W-1:0] s_side [NST+1];
  logic              s_vld  [NST+1];
  logic              adv;

  // Whole pipe moves together; it stalls only when a held result is refused.
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  assign s_data[0] = in_data;
  assign s_amt[0]  = in_amt[SHW-1:0];
  assign s_side[0] = in_addend;
  assign s_vld[0]  = in_valid;

  generate
    if (AMT_W > SHW) begin : g_amt_hi
      logic amt_hi_unused;
      assign amt_hi_unused = ^in_amt[AMT_W-1:SHW];
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < NST; i++) begin : g_stage
      localparam bit R4 = stage_is_radix4(i, SHW);
      localparam int SW = R4 ? 2 : 1;

      logic [SW-1:0]     sel;
      logic [DATA_W-1:0] rot;
      logic [DATA_W-1:0] post;

      assign sel = s_amt[i][2*i +: SW];

      rot4_sel_stage #(
        .W      (DATA_W),
        .UNIT   (stage_unit(i)),
        .RADIX4 (R4)
      ) u_sel (
        .din  (s_data[i]),
        .sel  (sel),
        .dout (rot)
      );

      if (FUSE_ADD && (i == NST - 1)) begin : g_fuse
        assign post = rot + s_side[i];
      end else begin : g_plain
        assign post = rot;
      end

      if (i < NREG) begin : g_reg
        logic [PW-1:0] pk_d;
        logic [PW-1:0] pk_q;
        assign pk_d = {post, s_amt[i], s_side[i]};
        rot4_stage_reg #(.PW(PW)) u_reg (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (adv),
          .vin   (s_vld[i]),
          .din   (pk_d),
          .vout  (s_vld[i+1]),
          .dout  (pk_q)
        );
        assign s_data[i+1] = pk_q[PW-1 -: DATA_W];
        assign s_amt[i+1]  = pk_q[DATA_W +: SHW];
        assign s_side[i+1] = pk_q[DATA_W-1:0];
      end else begin : g_wire
        assign s_data[i+1] = post;
        assign s_amt[i+1]  = s_amt[i];
        assign s_side[i+1] = s_side[i];
        assign s_vld[i+1]  = s_vld[i];
      end
    end
  endgenerate

  logic [SHW-1:0] amt_tail_unused;
  assign amt_tail_unused = s_amt[NST];

  assign out_valid  = s_vld[NST];
  assign out_data   = s_data[NST];
  assign out_addend = s_side[NST];

  // R6: a refused result stays put.
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addend)));

  // R7: an empty output never blocks the input.
  p_ready_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  generate
    if (NREG > 0) begin : g_rst_chk
      // R8: nothing emerges on the first edge after reset.
      p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);
    end
  endgenerate

endmodule

// File: tb/radix4_rotator_bench.sv
`timescale 1ns/1ps
module radix4_rotator_bench;

  localparam int N = 3;
  localparam int PIPE_OF [N] = '{2, 3, 0};
  localparam bit FUSE_OF [N] = '{1'b1, 1'b0, 1'b0};
  localparam int N_RANDOM = 300;
  localparam int WATCHDOG = 150000;

  typedef struct {
    logic [31:0] data;
    logic [31:0] side;
    int          cyc;
    int          req;
    bit          lat;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        iv   [N];
  logic        ird  [N];
  logic [31:0] idat [N];
  logic [7:0]  iamt [N];
  logic [31:0] iadd [N];
  logic        ov   [N];
  logic        ordy [N];
  logic [31:0] odat [N];
  logic [31:0] oadd [N];
  bit          directed [N];
  bit          held [N];
  logic [31:0] held_d [N];
  logic [31:0] held_s [N];

  exp_t q0[$];
  exp_t q1[$];
  exp_t q2[$];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  radix4_rotator #(.PIPE(PIPE_OF[0]), .FUSE_ADD(FUSE_OF[0])) u_radix4_rotator (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ird[0]), .in_data(idat[0]),
    .in_amt(iamt[0]), .in_addend(iadd[0]), .out_valid(ov[0]), .out_ready(ordy[0]),
    .out_data(odat[0]), .out_addend(oadd[0]));

  radix4_rotator #(.PIPE(PIPE_OF[1]), .FUSE_ADD(FUSE_OF[1])) u_radix4_rotator_plain (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ird[1]), .in_data(idat[1]),
    .in_amt(iamt[1]), .in_addend(iadd[1]), .out_valid(ov[1]), .out_ready(ordy[1]),
    .out_data(odat[1]), .out_addend(oadd[1]));

  radix4_rotator #(.PIPE(PIPE_OF[2]), .FUSE_ADD(FUSE_OF[2])) u_radix4_rotator_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(ird[2]), .in_data(idat[2]),
    .in_amt(iamt[2]), .in_addend(iadd[2]), .out_valid(ov[2]), .out_ready(ordy[2]),
    .out_data(odat[2]), .out_addend(oadd[2]));

  function automatic logic [31:0] rotl(input logic [31:0] x, input logic [4:0] a);
    logic [63:0] t;
    t = {x, x} << a;
    return t[63:32];
  endfunction

  function automatic string tag(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R?";
    endcase
  endfunction

  function automatic int q_size(input int k);
    case (k)
      0: return q0.size();
      1: return q1.size();
      default: return q2.size();
    endcase
  endfunction

  task automatic q_push(input int k, input exp_t e);
    case (k)
      0: q0.push_back(e);
      1: q1.push_back(e);
      default: q2.push_back(e);
    endcase
  endtask

  task automatic q_pop(input int k, output exp_t e);
    case (k)
      0: e = q0.pop_front();
      1: e = q1.pop_front();
      default: e = q2.pop_front();
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Stream driver: holds the word until an accepting edge.
  task automatic send(input int k, input logic [31:0] d, input logic [7:0] a,
                      input logic [31:0] s, input int req);
    exp_t e;
    @(negedge clk);
    iv[k] = 1'b1; idat[k] = d; iamt[k] = a; iadd[k] = s;
    forever begin
      #1;
      if (ird[k]) begin
        e.data = rotl(d, a[4:0]) + (FUSE_OF[k] ? s : 32'd0);
        e.side = s;
        e.cyc  = cyc;
        e.req  = req;
        e.lat  = directed[k];
        q_push(k, e);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic go_idle(input int k);
    @(negedge clk);
    iv[k] = 1'b0;
  endtask

  task automatic drain(input int k);
    while (q_size(k) != 0) @(negedge clk);
  endtask

  task automatic run_dut(input int k);
    int rq;
    rq = FUSE_OF[k] ? 3 : 1;
    for (int n = 0; n < N_RANDOM; n++) begin
      if (($urandom % 4) == 0) go_idle(k);
      send(k, $urandom, 8'($urandom), $urandom, rq);
    end
    go_idle(k);
    drain(k);
    directed[k] = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 32; a++) send(k, $urandom, 8'(a), $urandom, rq);
    for (int a = 0; a < 32; a++) send(k, 32'h8000_0001, 8'(a), 32'h0, rq);
    for (int a = 0; a < 32; a++) send(k, 32'h0000_0001 << (a % 7), 8'(a), $urandom, rq);
    // R2: upper amount bits set; result must follow amt[4:0] only
    for (int a = 0; a < 32; a++) send(k, $urandom, {3'($urandom) | 3'b001, 5'(a)}, $urandom, 2);
    send(k, 32'hFFFF_FFFF, 8'd13, 32'd1, rq);
    send(k, 32'h0, 8'hFF, 32'hFFFF_FFFF, rq);
    go_idle(k);
    drain(k);
  endtask

  // Output ready: random back-pressure, or always ready in the directed phase.
  initial begin
    for (int k = 0; k < N; k++) ordy[k] = 1'b1;
    forever begin
      @(negedge clk);
      for (int k = 0; k < N; k++)
        ordy[k] = directed[k] ? 1'b1 : (($urandom % 4) != 0);
    end
  end

  // Monitor: sample away from the edge, after drivers have settled.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        for (int k = 0; k < N; k++) begin
          if (held[k]) begin
            check(ov[k] === 1'b1, "R6", "stalled out_valid", 32'(ov[k]), 32'd1);
            check(odat[k] === held_d[k], "R6", "stalled out_data", odat[k], held_d[k]);
            check(oadd[k] === held_s[k], "R6", "stalled out_addend", oadd[k], held_s[k]);
            held[k] = 1'b0;
          end
          if (PIPE_OF[k] > 0)
            check(ird[k] === (ordy[k] || !ov[k]), "R7", "in_ready rule",
                  32'(ird[k]), 32'(ordy[k] || !ov[k]));
          if (ov[k] === 1'b1 && ordy[k]) begin
            if (q_size(k) == 0) begin
              check(1'b0, "R6", "result with nothing pending", odat[k], 32'h0);
            end else begin
              q_pop(k, e);
              check(odat[k] === e.data, tag(e.req), "out_data", odat[k], e.data);
              check(oadd[k] === e.side, "R4", "out_addend", oadd[k], e.side);
              if (e.lat)
                check(cyc - e.cyc == PIPE_OF[k], "R5", "latency",
                      32'(cyc - e.cyc), 32'(PIPE_OF[k]));
            end
          end else if (ov[k] === 1'b1) begin
            held[k]   = 1'b1;
            held_d[k] = odat[k];
            held_s[k] = oadd[k];
          end
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual=%0d cycles expected=below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) begin
      iv[k] = 1'b0; idat[k] = '0; iamt[k] = '0; iadd[k] = '0;
      directed[k] = 1'b0; held[k] = 1'b0;
    end
    repeat (4) @(negedge clk);
    #2;
    for (int k = 0; k < 2; k++)
      check(ov[k] === 1'b0, "R8", "out_valid in reset", 32'(ov[k]), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    for (int k = 0; k < N; k++) begin
      check(ov[k] === 1'b0, "R8", "out_valid after reset", 32'(ov[k]), 32'd0);
      check(ird[k] === 1'b1, "R7", "in_ready when empty", 32'(ird[k]), 32'd1);
    end
    fork
      run_dut(0);
      run_dut(1);
      run_dut(2);
    join
    repeat (4) @(negedge clk);
    for (int k = 0; k < N; k++)
      check(q_size(k) == 0, "R6", "items left undelivered", 32'(q_size(k)), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule